// File: doc/BRIEF.md
# Clock Prescaler and Power-Mode Controller

This block produces the system clock tick and the clock-gating enables for a small microcontroller. It runs in one of four power modes. The two oscillators are modelled as free-running single-cycle enables on a common reference clock. In the two run modes, the enable of the oscillator that drives the CPU goes into a prescaler. The prescaler divides it by 1, 2, 4 or 8 and gives one `sys_tick_o` pulse per divided period.

Software moves between modes with a request strobe. A request is accepted only while the CPU is running. Entering one of the two low-power modes records the run mode that was active. Any wake-up pulse whose mask bit is set brings the block back to that recorded mode. The gating outputs are decoded from the current mode and from two configuration bits. One bit keeps the fast oscillator alive in the slow run mode. The other lets the watchdog keep running in the deepest mode.

A new division ratio is taken only when a divided period completes. This means a shortened or stretched tick period never appears.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the mode is FAST (2'b00), the division ratio is 1 (setting 2'b00), and `sys_tick_o` is low.
- R2: Mode encoding is FAST 2'b00, SLOW 2'b01, IDLE 2'b10, STOP 2'b11. While the mode is FAST or SLOW, a request strobe with any mode code sets `mode_o` to that code at the next clock edge.
- R3: In FAST the fast, slow, CPU, wake-up-timer and watchdog gates are all high.
- R4: In SLOW the slow, CPU, wake-up-timer and watchdog gates are high, and the fast gate equals the keep-fast configuration bit.
- R5: In IDLE the slow, wake-up-timer and watchdog gates are high, and the fast and CPU gates are low.
- R6: In STOP the fast, slow, CPU and wake-up-timer gates are low, and the watchdog gate equals the watchdog-run-in-stop bit.
- R7: While in IDLE or STOP, mode requests have no effect. A wake-up pulse whose mask bit is clear also has no effect. Wake-up pulses in FAST or SLOW have no effect.
- R8: In IDLE or STOP, a cycle in which any wake-up bit and its mask bit are both high returns `mode_o` at the next edge to the run mode that was active when the low-power mode was entered.
- R9: The counted source is the fast enable in FAST and the slow enable in SLOW; nothing is counted in IDLE or STOP. With ratio setting s, `sys_tick_o` pulses for one cycle, one cycle after every 2^s-th counted pulse.
- R10: The ratio setting is sampled only in the cycle that completes a divided period. Later periods use it, and the period in progress keeps the old ratio.
- R11: Any change of mode clears the period count, so the first counted pulse after the change begins a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_en_i | input | 1 | Fast oscillator pulse enable |
| slow_en_i | input | 1 | Slow oscillator pulse enable |
| mode_req_valid_i | input | 1 | Mode request strobe |
| mode_req_i | input | 2 | Requested mode code |
| div_sel_i | input | 2 | Division setting, ratio 2^value |
| keep_fast_i | input | 1 | Keep fast oscillator on in SLOW |
| wdt_stop_run_i | input | 1 | Watchdog keeps running in STOP |
| wake_i | input | NUM_WAKE | Wake-up event pulses |
| wake_mask_i | input | NUM_WAKE | Per-event wake enable |
| mode_o | output | 2 | Current mode |
| fast_gate_o | output | 1 | Fast oscillator enable |
| slow_gate_o | output | 1 | Slow oscillator enable |
| cpu_gate_o | output | 1 | CPU clock enable |
| wkt_gate_o | output | 1 | Wake-up timer clock enable |
| wdt_gate_o | output | 1 | Watchdog clock enable |
| sys_tick_o | output | 1 | Divided system clock tick |

## Verification
A request or an enabled wake-up sampled at one edge shows on `mode_o` after that same edge, which is one register stage. The gates are combinational from `mode_o` and the two configuration bits, so they follow the mode in the same cycle. A counted source pulse that completes a period shows as `sys_tick_o` in the cycle after its edge. The bench drives inputs and compares at the falling edge. Its reference model advances at each rising edge from the inputs held across that edge. Each comparison therefore uses the state that those inputs produced, with no extra delay.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    typedef enum logic [1:0] {
        PM_FAST = 2'b00,
        PM_SLOW = 2'b01,
        PM_IDLE = 2'b10,
        PM_STOP = 2'b11
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        pm_mode_e ret;
    } pm_state_t;

    typedef struct packed {
        logic fast;
        logic slow;
        logic cpu;
        logic wkt;
        logic wdt;
    } pm_gates_t;

    function automatic logic pm_is_run(input pm_mode_e m);
        return (m == PM_FAST) || (m == PM_SLOW);
    endfunction

endpackage

// File: rtl/clkpm_mode_fsm.sv
module clkpm_mode_fsm
    import clkpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  pm_mode_e req_mode,
    input  logic     wake_hit,
    output pm_mode_e mode_q,
    output logic     mode_chg
);

    pm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pm_is_run(st_q.mode)) begin
            if (req_valid) begin
                if (!pm_is_run(req_mode)) begin
                    st_d.ret = st_q.mode;
                end
                st_d.mode = req_mode;
            end
        end else if (wake_hit) begin
            st_d.mode = st_q.ret;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_FAST, ret: PM_FAST};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign mode_chg = (st_d.mode != st_q.mode);

endmodule

// File: rtl/clkpm_gate_dec.sv
module clkpm_gate_dec
    import clkpm_pkg::*;
(
    input  pm_mode_e  mode,
    input  logic      keep_fast,
    input  logic      wdt_stop_run,
    input  logic      fast_en,
    input  logic      slow_en,
    output pm_gates_t gates,
    output logic      src_en
);

    always_comb begin
        gates  = '0;
        src_en = 1'b0;
        unique case (mode)
            PM_FAST: begin
                gates  = '{fast: 1'b1, slow: 1'b1, cpu: 1'b1, wkt: 1'b1, wdt: 1'b1};
                src_en = fast_en;
            end
            PM_SLOW: begin
                gates  = '{fast: keep_fast, slow: 1'b1, cpu: 1'b1, wkt: 1'b1, wdt: 1'b1};
                src_en = slow_en;
            end
            PM_IDLE: begin
                gates  = '{fast: 1'b0, slow: 1'b1, cpu: 1'b0, wkt: 1'b1, wdt: 1'b1};
            end
            PM_STOP: begin
                gates  = '{fast: 1'b0, slow: 1'b0, cpu: 1'b0, wkt: 1'b0, wdt: wdt_stop_run};
            end
            default: begin
                gates  = '0;
            end
        endcase
    end

endmodule

// File: rtl/clkpm_prescaler.sv
module clkpm_prescaler #(
    parameter int DIV_SEL_W = 2,
    localparam int CNT_W    = (1 << DIV_SEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_en,
    input  logic                 restart,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [DIV_SEL_W-1:0] ratio;
        logic                 tick;
    } div_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    div_state_t       st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             wrap;

    always_comb begin
        lim  = (ONE << st_q.ratio) - ONE;
        wrap = src_en && (st_q.cnt == lim);
        st_d      = st_q;
        st_d.tick = wrap;
        if (wrap) begin
            st_d.ratio = div_sel;
        end
        if (restart || wrap) begin
            st_d.cnt = '0;
        end else if (src_en) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
    import clkpm_pkg::*;
#(
    parameter int NUM_WAKE  = 4,
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast_en_i,
    input  logic                 slow_en_i,
    input  logic                 mode_req_valid_i,
    input  logic [1:0]           mode_req_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    input  logic                 keep_fast_i,
    input  logic                 wdt_stop_run_i,
    input  logic [NUM_WAKE-1:0]  wake_i,
    input  logic [NUM_WAKE-1:0]  wake_mask_i,
    output logic [1:0]           mode_o,
    output logic                 fast_gate_o,
    output logic                 slow_gate_o,
    output logic                 cpu_gate_o,
    output logic                 wkt_gate_o,
    output logic                 wdt_gate_o,
    output logic                 sys_tick_o
);

    pm_mode_e  cur_mode;
    logic      mode_chg;
    logic      wake_hit;
    logic      src_en;
    pm_gates_t gates;

    assign wake_hit = |(wake_i & wake_mask_i);

    clkpm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mode_req_valid_i),
        .req_mode  (pm_mode_e'(mode_req_i)),
        .wake_hit  (wake_hit),
        .mode_q    (cur_mode),
        .mode_chg  (mode_chg)
    );

    clkpm_gate_dec u_dec (
        .mode         (cur_mode),
        .keep_fast    (keep_fast_i),
        .wdt_stop_run (wdt_stop_run_i),
        .fast_en      (fast_en_i),
        .slow_en      (slow_en_i),
        .gates        (gates),
        .src_en       (src_en)
    );

    clkpm_prescaler #(
        .DIV_SEL_W (DIV_SEL_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .restart (mode_chg),
        .div_sel (div_sel_i),
        .tick    (sys_tick_o)
    );

    assign mode_o      = cur_mode;
    assign fast_gate_o = gates.fast;
    assign slow_gate_o = gates.slow;
    assign cpu_gate_o  = gates.cpu;
    assign wkt_gate_o  = gates.wkt;
    assign wdt_gate_o  = gates.wdt;

endmodule

// File: rtl/clkpm_checker.sv
module clkpm_checker #(
    parameter int NUM_WAKE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_o,
    input logic                fast_gate_o,
    input logic                slow_gate_o,
    input logic                cpu_gate_o,
    input logic                wkt_gate_o,
    input logic                wdt_gate_o,
    input logic                keep_fast_i,
    input logic                wdt_stop_run_i,
    input logic [NUM_WAKE-1:0] wake_i,
    input logic [NUM_WAKE-1:0] wake_mask_i,
    input logic                sys_tick_o
);

    logic hit;
    assign hit = |(wake_i & wake_mask_i);

    a_r3_fast_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (fast_gate_o && slow_gate_o && cpu_gate_o && wkt_gate_o));

    a_r4_slow_fast_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (cpu_gate_o && slow_gate_o && (fast_gate_o == keep_fast_i)));

    a_r5_idle_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (!cpu_gate_o && !fast_gate_o && slow_gate_o && wkt_gate_o));

    a_r6_stop_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> (!fast_gate_o && !slow_gate_o && !wkt_gate_o
                               && (wdt_gate_o == wdt_stop_run_i)));

    a_r7_lowpower_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1] && !hit) |=> $stable(mode_o));

    a_r8_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1] && hit) |=> !mode_o[1]);

    a_r9_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tick_o |-> !$past(mode_o[1]));

endmodule

bind clk_pwr_ctrl clkpm_checker #(.NUM_WAKE(NUM_WAKE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_o         (mode_o),
    .fast_gate_o    (fast_gate_o),
    .slow_gate_o    (slow_gate_o),
    .cpu_gate_o     (cpu_gate_o),
    .wkt_gate_o     (wkt_gate_o),
    .wdt_gate_o     (wdt_gate_o),
    .keep_fast_i    (keep_fast_i),
    .wdt_stop_run_i (wdt_stop_run_i),
    .wake_i         (wake_i),
    .wake_mask_i    (wake_mask_i),
    .sys_tick_o     (sys_tick_o)
);

// File: tb/sim_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_clk_pwr_ctrl;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fast_en = 1'b0, slow_en = 1'b0;
    logic          req_v = 1'b0;
    logic [1:0]    req_m = 2'b00;
    logic [1:0]    div_sel = 2'b00;
    logic          keep_fast = 1'b0, wdt_run = 1'b0;
    logic [NW-1:0] wake = '0, wmask = '0;
    logic [1:0]    mode;
    logic          g_fast, g_slow, g_cpu, g_wkt, g_wdt, tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 0, m_ret = 0, m_cnt = 0, m_ratio = 0;
    bit m_tick = 1'b0;

    always #2 clk = ~clk;

    clk_pwr_ctrl #(.NUM_WAKE(NW), .DIV_SEL_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .fast_en_i(fast_en), .slow_en_i(slow_en),
        .mode_req_valid_i(req_v), .mode_req_i(req_m), .div_sel_i(div_sel),
        .keep_fast_i(keep_fast), .wdt_stop_run_i(wdt_run), .wake_i(wake),
        .wake_mask_i(wmask), .mode_o(mode), .fast_gate_o(g_fast),
        .slow_gate_o(g_slow), .cpu_gate_o(g_cpu), .wkt_gate_o(g_wkt),
        .wdt_gate_o(g_wdt), .sys_tick_o(tick)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ret = 0; m_cnt = 0; m_ratio = 0; m_tick = 1'b0;
        end else begin
            bit src, wrap, hit;
            int nmode;
            src  = (m_mode == 0) ? fast_en : (m_mode == 1) ? slow_en : 1'b0;
            wrap = src && (m_cnt == (1 << m_ratio) - 1);
            hit  = |(wake & wmask);
            nmode = m_mode;
            if (m_mode < 2) begin
                if (req_v) begin
                    if (req_m >= 2) m_ret = m_mode;
                    nmode = req_m;
                end
            end else if (hit) begin
                nmode = m_ret;
            end
            m_tick = wrap;
            if (wrap) m_ratio = div_sel;
            if (wrap || nmode != m_mode) m_cnt = 0;
            else if (src) m_cnt = m_cnt + 1;
            m_mode = nmode;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        string gt;
        bit ef, es, ec, ek, ed;
        case (m_mode)
            0: begin gt = "R3"; ef = 1; es = 1; ec = 1; ek = 1; ed = 1; end
            1: begin gt = "R4"; ef = keep_fast; es = 1; ec = 1; ek = 1; ed = 1; end
            2: begin gt = "R5"; ef = 0; es = 1; ec = 0; ek = 1; ed = 1; end
            default: begin gt = "R6"; ef = 0; es = 0; ec = 0; ek = 0; ed = wdt_run; end
        endcase
        chk("R2/R7/R8 mode", int'(mode), m_mode);
        chk({gt, " fast gate"}, int'(g_fast), int'(ef));
        chk({gt, " slow gate"}, int'(g_slow), int'(es));
        chk({gt, " cpu gate"}, int'(g_cpu), int'(ec));
        chk({gt, " wkt gate"}, int'(g_wkt), int'(ek));
        chk({gt, " wdt gate"}, int'(g_wdt), int'(ed));
        chk("R9/R10/R11 tick", int'(tick), int'(m_tick));
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        compare_all();
        req_v = 1'b0;
        wake  = '0;
    endtask

    task automatic request(input logic [1:0] m);
        req_m = m; req_v = 1'b1;
        step();
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mode", int'(mode), 0);
        chk("R1 tick", int'(tick), 0);
        rst_n = 1'b1;
        // R1: ratio 1 -> tick every fast pulse
        fast_en = 1'b1;
        step();
        step();
        chk("R1 ratio one tick", int'(tick), 1);
        // R9/R10: divide by each ratio, change mid-period
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            for (int k = 0; k < 20; k++) begin
                if (k == 5) div_sel = 2'(3 - s);
                step();
            end
            div_sel = 2'(s);
            for (int k = 0; k < 20; k++) step();
        end
        // R9: sparse fast pulses with ratio 4
        div_sel = 2'd2;
        for (int k = 0; k < 40; k++) begin
            fast_en = (k % 3 == 0);
            step();
        end
        // R2/R4: SLOW with keep-fast both ways, slow source counted
        fast_en = 1'b1;
        request(2'b01);
        for (int k = 0; k < 40; k++) begin
            slow_en = (k % 4 == 1);
            keep_fast = (k >= 20);
            step();
        end
        // R5/R7/R8: IDLE from SLOW, masked wake ignored, enabled wake returns
        request(2'b10);
        request(2'b00);
        wmask = 4'b0101;
        wake = 4'b1010;
        step();
        step();
        wake = 4'b0100;
        step();
        chk("R8 return to SLOW", int'(mode), 1);
        // R6: STOP from FAST with both watchdog settings
        request(2'b00);
        request(2'b11);
        wdt_run = 1'b1;
        step();
        wdt_run = 1'b0;
        step();
        request(2'b01);
        chk("R7 request ignored in STOP", int'(mode), 3);
        wake = 4'b0001;
        step();
        chk("R8 return to FAST", int'(mode), 0);
        // R11: mode change mid-period clears count
        div_sel = 2'd3;
        for (int k = 0; k < 13; k++) step();
        request(2'b01);
        slow_en = 1'b1;
        for (int k = 0; k < 20; k++) step();
        // Mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom % 100;
            fast_en   = ($urandom % 2) == 0;
            slow_en   = ($urandom % 5) == 0;
            keep_fast = ($urandom % 2) == 0;
            wdt_run   = ($urandom % 2) == 0;
            wmask     = NW'($urandom);
            if (r < 8) begin
                req_m = 2'($urandom); req_v = 1'b1;
            end
            if (r > 90) wake = NW'($urandom);
            if (r == 50) div_sel = 2'($urandom);
            step();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule